// File: doc/BRIEF.md
# Oscillator Trim Loop Filter

This block closes the digital part of a frequency-locking loop around a digitally controlled oscillator. It holds a single 12-bit trim word. The upper nibble of that word drives the oscillator's divider select. The lower byte drives its delay-stage select. A frequency comparator outside the block measures a slow base clock against its nominal value. At the end of each measurement it pulses an update strobe and supplies two flags:

- a direction flag, set when the base clock ran slow;
- a band flag, set when the error was outside ±15%.

On each strobe the filter moves the trim word by a coarse step of 32 or a fine step of 1. Lowering the word speeds the oscillator up, and raising it slows the oscillator down. All arithmetic is done on the full word, so a carry or borrow out of the stage byte changes the divider nibble. The word is allowed to wrap at both ends.

When the nibble holds a code above 9, the divider output shows 9, which is the slowest setting. The loop then climbs back with its ordinary subtract steps; nothing reloads the word. A stable indicator reports whether the most recent measurement fell inside the ±15% band.

Top module: `dco_trim_filter`

## Requirements
- R1: After reset the divider output is 0x4, the stage output is 0x80 (trim word 0x480), and the stable output is 0.
- R2: On a cycle without a strobe, the divider, stage and stable outputs keep their values, whatever the direction and band flags are.
- R3: A strobe with direction=1 (base clock slow) and band=1 (outside ±15%) lowers the trim word by 32, one cycle later.
- R4: A strobe with direction=1 and band=0 lowers the trim word by 1.
- R5: A strobe with direction=0 and band=0 raises the trim word by 1. direction=0 also covers an exact match.
- R6: A strobe with direction=0 and band=1 raises the trim word by 32.
- R7: The trim word is the divider nibble (bits 11:8) joined to the stage byte (bits 7:0). Carries and borrows cross from bit 7 into bit 8, and the word wraps modulo 4096 (0xFFF+1 gives 0x000, 0x000-1 gives 0xFFF).
- R8: When the divider nibble of the trim word is 0xA to 0xF, the divider output is 0x9. The stage output still shows the raw stage byte.
- R9: One cycle after a strobe, the stable output is 1 if band was 0 and 0 if band was 1.
- R10: From a wrapped word with a nibble of 0xA to 0xF, the normal subtract steps alone bring the word back to a target code. Once there, the word settles between the target and the target plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_i | input | 1 | Single-cycle strobe marking the end of a comparison |
| slow_i | input | 1 | 1: base clock slower than nominal; 0: faster or equal |
| wide_i | input | 1 | 1: error outside the ±15% band |
| div_o | output | 4 | Divider select, clamped to 9 |
| stg_o | output | 8 | Delay-stage select |
| stable_o | output | 1 | Last measured error was inside the ±15% band |

## Verification
The assertions assume that the strobe is one cycle wide. They also assume that the direction and band flags are valid in the cycle the strobe is high. The flags may take any value on other cycles.

The bench drives the flags and the strobe on falling edges, always in a single-cycle pulse. Between pulses it toggles the flags freely to show they are ignored. It keeps its own copy of the trim word, which makes the expected clamped divider observable even when the raw nibble is above 9. A closed-loop phase stands in for an ideal comparator: it derives the two flags by comparing the modelled word with a target code.

// File: rtl/dco_trim_filter.sv
module dco_trim_filter #(
  parameter int unsigned WORD_W     = 12,
  parameter int unsigned DIV_W      = 4,
  parameter int unsigned COARSE     = 32,
  parameter int unsigned FINE       = 1,
  parameter int unsigned DIV_MAX    = 9,
  parameter int unsigned RESET_WORD = 'h480
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic             slow_i,
  input  logic             wide_i,
  output logic [DIV_W-1:0] div_o,
  output logic [WORD_W-DIV_W-1:0] stg_o,
  output logic             stable_o
);
  localparam int unsigned STG_W = WORD_W - DIV_W;

  logic [WORD_W-1:0] word_q, word_d, step;
  logic [DIV_W-1:0]  raw_div;
  logic              stable_q;

  assign step   = wide_i ? WORD_W'(COARSE) : WORD_W'(FINE);
  assign word_d = slow_i ? word_q - step : word_q + step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q   <= WORD_W'(RESET_WORD);
      stable_q <= 1'b0;
    end else if (upd_i) begin
      word_q   <= word_d;
      stable_q <= ~wide_i;
    end
  end

  assign raw_div  = word_q[WORD_W-1 -: DIV_W];
  assign div_o    = (raw_div > DIV_W'(DIV_MAX)) ? DIV_W'(DIV_MAX) : raw_div;
  assign stg_o    = word_q[STG_W-1:0];
  assign stable_o = stable_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(div_o) && $stable(stg_o) && $stable(stable_o));

  p_coarse_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i && slow_i && wide_i |=> stg_o == STG_W'($past(stg_o) - STG_W'(COARSE)));

  p_fine_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i && slow_i && !wide_i |=> stg_o == STG_W'($past(stg_o) - STG_W'(FINE)));

  p_fine_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i && !slow_i && !wide_i |=> stg_o == STG_W'($past(stg_o) + STG_W'(FINE)));

  p_coarse_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i && !slow_i && wide_i |=> stg_o == STG_W'($past(stg_o) + STG_W'(COARSE)));

  p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    div_o <= DIV_W'(DIV_MAX));

  p_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> stable_o == !$past(wide_i));
endmodule

// File: tb/dco_trim_filter_bench.sv
module dco_trim_filter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TARGET     = 'h2A5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_i = 1'b0, slow_i = 1'b0, wide_i = 1'b0;
  logic [3:0] div_o;
  logic [7:0] stg_o;
  logic       stable_o;

  logic [11:0] mw;
  logic        mstable;
  int vectors = 0, miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dco_trim_filter u_dco_trim_filter (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .slow_i(slow_i), .wide_i(wide_i),
    .div_o(div_o), .stg_o(stg_o), .stable_o(stable_o)
  );

  function automatic logic [3:0] clamp_div(logic [11:0] w);
    return (w[11:8] > 4'd9) ? 4'd9 : w[11:8];
  endfunction

  task automatic check(string tag);
    logic [3:0] ed;
    ed = clamp_div(mw);
    vectors++;
    if (div_o !== ed || stg_o !== mw[7:0] || stable_o !== mstable) begin
      miscompares++;
      $display("FAIL %s: got div=%h stg=%h stable=%b expected div=%h stg=%h stable=%b",
               tag, div_o, stg_o, stable_o, ed, mw[7:0], mstable);
    end
  endtask

  task automatic step(logic s, logic w, string tag);
    @(negedge clk);
    upd_i = 1'b1; slow_i = s; wide_i = w;
    @(negedge clk);
    upd_i = 1'b0; slow_i = ~s; wide_i = ~w;
    mw = s ? mw - (w ? 12'd32 : 12'd1) : mw + (w ? 12'd32 : 12'd1);
    mstable = ~w;
    check(tag);
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      slow_i = i[0]; wide_i = i[1];
      check("R2");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mw = 12'h480; mstable = 1'b0;
    @(negedge clk);
    check("R1");
    idle_cycles(4);

    step(1'b1, 1'b1, "R3");
    step(1'b1, 1'b0, "R4");
    step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, "R6");
    idle_cycles(4);
    step(1'b1, 1'b0, "R9");
    idle_cycles(3);

    for (int i = 0; i < 130; i++) begin
      logic [11:0] nx;
      nx = mw + 12'd32;
      step(1'b0, 1'b1, (nx[11:8] > 4'd9) ? "R8" : "R7");
    end
    for (int i = 0; i < 'hC1; i++)
      step(1'b1, 1'b0, "R7");
    for (int i = 0; i < 40; i++) begin
      logic [11:0] nx;
      nx = mw - 12'd32;
      step(1'b1, 1'b1, (nx[11:8] > 4'd9) ? "R8" : "R7");
    end

    for (int i = 0; i < 200; i++) begin
      int d;
      d = int'(mw) - TARGET;
      step(d > 0, (d >= 32) || (d <= -32), "R10");
    end
    vectors++;
    if (!((mw == 12'(TARGET) || mw == 12'(TARGET + 1)) &&
          {div_o, stg_o} == mw && stable_o)) begin
      miscompares++;
      $display("FAIL R10: got code=%h stable=%b expected %h or %h with stable=1",
               {div_o, stg_o}, stable_o, TARGET, TARGET + 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule